// File: doc/BRIEF.md
# Audio Serial Transmitter

This block turns parallel audio samples into a three-wire serial stream: a bit clock, a frame clock and one data line. It runs directly on an audio master clock supplied from outside the chip. That clock is a fixed multiple of the sample rate: 256, 384, 512 or 768 times fs. The block divides it down to form the bit clock and the frame clock. Data leaves most significant bit first. Data and the frame clock change only on the falling edge of the bit clock, so a receiver samples on the rising edge.

The block has two framings. The first is a left-justified stereo framing. A sample word from 1 to 32 bits wide is sent with its MSB in the first bit slot after each frame clock edge. The second is a PCM highway framing. A one-slot sync pulse marks the start of each frame, and an 8-bit sample follows it. Samples enter through a valid/ready handshake into a one-sample holding stage, and each new frame takes up the held sample. If no sample is waiting at a frame start, the previous sample is sent again and a sticky underrun flag is raised.

Top module: `audio_ser_tx`

## Requirements
- R1: The bit clock period is 8 master clock cycles for ratio codes 0 (256 fs) and 2 (512 fs), and 12 cycles for codes 1 (384 fs) and 3 (768 fs). The bit clock is low for the first half of each period and high for the second half.
- R2: A frame is 32 bit clocks long for ratio codes 0 and 1, and 64 bit clocks long for codes 2 and 3. This gives 256, 384, 512 or 768 master clocks per frame. In left-justified mode the frame clock is high for the first half of the frame (left channel) and low for the second half (right channel).
- R3: In left-justified mode (`cfg_pcm`=0) the sample width is W = `cfg_wid_m1`+1. The sample is taken from bits W-1..0 of the input word, and bits above W-1 are ignored. Bit W-1 is sent in the first slot of the half-frame, then the lower bits follow in descending order. The slots after the last sample bit carry 0.
- R4: When W is larger than the number of slots in a half-frame, only the upper bits of the sample that fit are sent. With a 16-slot half-frame these are bits W-1 down to W-16.
- R5: The right-channel sample (`in_right`) is sent in the second half-frame with the same alignment as the left.
- R6: In PCM mode (`cfg_pcm`=1) the frame clock is high only during slot 0, and the data line is 0 in that slot. Bits 7..0 of `in_left` go out in slots 1 to 8, MSB first. All other slots carry 0, and `in_right` has no effect.
- R7: `sdata` and `fclk` change only on cycles in which `bclk` falls.
- R8: `in_ready` is high while the holding stage is empty. An accepted sample drives `in_ready` low, and it stays low until the next frame starts and moves the sample to the output.
- R9: If the holding stage is empty at a frame start, the previous sample is sent again and `underrun` goes high. Once high, `underrun` stays high until reset.
- R10: Ratio, format and width are sampled at each frame start. A change made in the middle of a frame takes effect from the next frame.
- R11: During reset and just after it: `bclk`=0, `fclk`=1, `sdata`=0, `in_ready`=1, `underrun`=0. The first frame after reset sends all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock at 256/384/512/768 fs |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ratio | input | 2 | Master-to-sample clock ratio code |
| cfg_pcm | input | 1 | 0 = left-justified stereo, 1 = PCM highway |
| cfg_wid_m1 | input | 5 | Sample width minus one (left-justified mode) |
| in_left | input | 32 | Left sample (or PCM sample in bits 7..0) |
| in_right | input | 32 | Right sample |
| in_valid | input | 1 | Sample word offered |
| in_ready | output | 1 | Holding stage can take a sample |
| bclk | output | 1 | Serial bit clock |
| fclk | output | 1 | Frame / word clock, or PCM sync pulse |
| sdata | output | 1 | Serial data, MSB first |
| underrun | output | 1 | Sticky flag: a frame started with no new sample |

## Verification
The bench builds the block with its default parameters: a 32-bit maximum sample word and an 8-bit PCM sample. With a 32-bit word, a full-width sample in the short 32-slot frame is cut to its upper half, so the truncation case can be reached as well as the zero-padded cases at widths 8, 16, 20 and 24. All four ratio codes are used. This covers both bit-clock divisors and both frame lengths, and it lets the bench change the configuration mid-frame from a short frame to a long one.

// File: rtl/aso_pkg.sv
`timescale 1ns/1ps
// Package for the audio serial transmitter.
// It holds the divider and frame-length constants, the decoded-timing
// struct and the ratio decode function.
// Assumes: master clock per frame = divider * slots, for every ratio code.
package aso_pkg;

    localparam int DIV_A   = 8;    // bit-clock divider for ratio codes 0 and 2
    localparam int DIV_B   = 12;   // bit-clock divider for ratio codes 1 and 3
    localparam int SLOTS_A = 32;   // frame length for ratio codes 0 and 1
    localparam int SLOTS_B = 64;   // frame length for ratio codes 2 and 3
    localparam int PH_W    = $clog2(DIV_B);
    localparam int SL_W    = $clog2(SLOTS_B);

    typedef enum logic {
        FMT_LJ  = 1'b0,
        FMT_PCM = 1'b1
    } fmt_e;

    typedef struct packed {
        logic [PH_W-1:0] div_m1;   // last phase count of a bit slot
        logic [PH_W-1:0] half_m1;  // phase count at which bclk rises
        logic [SL_W-1:0] last;     // last slot index of a frame
        logic [SL_W-1:0] half;     // first slot of the right half-frame
    } tim_t;

    // Maps a ratio code to divider and frame-length values
    function automatic tim_t ratio_decode(input logic [1:0] code);
        tim_t t;
        int   div;
        int   slots;
        div       = code[0] ? DIV_B : DIV_A;
        slots     = code[1] ? SLOTS_B : SLOTS_A;
        t.div_m1  = PH_W'(div - 1);
        t.half_m1 = PH_W'(div / 2 - 1);
        t.last    = SL_W'(slots - 1);
        t.half    = SL_W'(slots / 2);
        return t;
    endfunction

endpackage

// File: rtl/aso_timebase.sv
`timescale 1ns/1ps
// Timebase: divides the master clock into bit slots and frames.
// It registers the bit clock and gives strobes for the end of a slot and
// the end of a frame, plus a look-ahead for the next slot (left half,
// right half start).
// Assumes: the ratio code is sampled only in reset and at frame ends.
module aso_timebase
    import aso_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_ratio,
    output logic       bclk,
    output logic       slot_end,
    output logic       frame_end,
    output logic       nxt_left,
    output logic       nxt_half_start
);

    logic [1:0]      ratio_q;
    logic [PH_W-1:0] ph;
    logic [SL_W-1:0] slot;
    logic [SL_W-1:0] slot_inc;
    tim_t            tim;

    // Decode the latched ratio and form the look-ahead flags
    always_comb begin
        tim            = ratio_decode(ratio_q);
        slot_inc       = slot + 1'b1;
        slot_end       = (ph == tim.div_m1);
        frame_end      = slot_end && (slot == tim.last);
        nxt_left       = frame_end || (slot_inc < tim.half);
        nxt_half_start = !frame_end && (slot_inc == tim.half);
    end

    // Phase, slot and bit-clock registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= cfg_ratio;
            ph      <= '0;
            slot    <= '0;
            bclk    <= 1'b0;
        end else begin
            if (slot_end) begin
                ph <= '0;
            end else begin
                ph <= ph + 1'b1;
            end
            if (ph == tim.half_m1) begin
                bclk <= 1'b1;
            end else if (slot_end) begin
                bclk <= 1'b0;
            end
            if (frame_end) begin
                slot    <= '0;
                ratio_q <= cfg_ratio;
            end else if (slot_end) begin
                slot <= slot_inc;
            end
        end
    end

endmodule

// File: rtl/aso_hold.sv
`timescale 1ns/1ps
// Holding stage: a one-sample buffer behind a valid/ready handshake.
// At each frame end it hands the pending sample to the active register.
// If nothing is pending it keeps the active sample and sets a sticky
// underrun flag.
// Assumes: frame_end is a one-cycle strobe from the timebase.
module aso_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_left,
    input  logic [W-1:0] in_right,
    output logic         in_ready,
    input  logic         frame_end,
    output logic [W-1:0] load_left,
    output logic [W-1:0] act_right,
    output logic         underrun
);

    logic         pend_full;
    logic [W-1:0] pend_l;
    logic [W-1:0] pend_r;
    logic [W-1:0] act_l;
    logic [W-1:0] act_r;

    // Ready while empty; at a frame end the next left word is the pending one when present
    always_comb begin
        in_ready  = !pend_full;
        load_left = pend_full ? pend_l : act_l;
        act_right = act_r;
    end

    // Accept, hand over and underrun tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_full <= 1'b0;
            pend_l    <= '0;
            pend_r    <= '0;
            act_l     <= '0;
            act_r     <= '0;
            underrun  <= 1'b0;
        end else begin
            if (frame_end) begin
                if (pend_full) begin
                    act_l     <= pend_l;
                    act_r     <= pend_r;
                    pend_full <= 1'b0;
                end else begin
                    underrun <= 1'b1;
                end
            end
            if (in_valid && !pend_full) begin
                pend_l    <= in_left;
                pend_r    <= in_right;
                pend_full <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/aso_shift.sv
`timescale 1ns/1ps
// Output shifter: loads sample words at frame and half-frame starts and
// shifts them out MSB first, one bit per slot. It drives the frame clock
// for either framing.
// Assumes: format and width are sampled in reset and at frame ends, and
// PCM_W < W.
module aso_shift
    import aso_pkg::*;
#(
    parameter int W     = 32,
    parameter int PCM_W = 8,
    localparam int WID_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_pcm,
    input  logic [WID_W-1:0] cfg_wid_m1,
    input  logic             slot_end,
    input  logic             frame_end,
    input  logic             nxt_left,
    input  logic             nxt_half_start,
    input  logic [W-1:0]     smp_left,
    input  logic [W-1:0]     smp_right,
    output logic             sdata,
    output logic             fclk
);

    fmt_e             fmt_q;
    logic [WID_W-1:0] wid_q;
    logic [W-1:0]     sh;
    logic [W-1:0]     word;
    logic [W-1:0]     nsh;
    logic             nsd;
    logic             nfc;
    fmt_e             eff_fmt;
    logic [WID_W-1:0] eff_wid;

    // Moves a right-aligned sample of width m1+1 up to the MSB
    function automatic logic [W-1:0] align(input logic [W-1:0] w, input logic [WID_W-1:0] m1);
        logic [WID_W-1:0] amt;
        amt = WID_W'(W - 1) - m1;
        return w << amt;
    endfunction

    // Next data bit, shift contents and frame clock for the coming slot
    always_comb begin
        eff_fmt = frame_end ? fmt_e'(cfg_pcm) : fmt_q;
        eff_wid = frame_end ? cfg_wid_m1 : wid_q;
        word    = '0;
        nsd     = sh[W-1];
        nsh     = sh << 1;
        nfc     = (fmt_q == FMT_PCM) ? 1'b0 : nxt_left;
        if (frame_end) begin
            nfc = 1'b1;
            if (eff_fmt == FMT_PCM) begin
                nsd = 1'b0;
                nsh = {smp_left[PCM_W-1:0], {(W-PCM_W){1'b0}}};
            end else begin
                word = align(smp_left, eff_wid);
                nsd  = word[W-1];
                nsh  = word << 1;
            end
        end else if (nxt_half_start && (fmt_q == FMT_LJ)) begin
            word = align(smp_right, wid_q);
            nsd  = word[W-1];
            nsh  = word << 1;
            nfc  = 1'b0;
        end
    end

    // Output registers change only at slot ends, where bclk falls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= fmt_e'(cfg_pcm);
            wid_q <= cfg_wid_m1;
            sh    <= '0;
            sdata <= 1'b0;
            fclk  <= 1'b1;
        end else if (slot_end) begin
            sh    <= nsh;
            sdata <= nsd;
            fclk  <= nfc;
            if (frame_end) begin
                fmt_q <= eff_fmt;
                wid_q <= eff_wid;
            end
        end
    end

endmodule

// File: rtl/audio_ser_tx.sv
`timescale 1ns/1ps
// Audio serial transmitter top. It ties the timebase, the holding stage
// and the output shifter together.
// Assumes: clk is the master clock at 256/384/512/768 fs and rst_n is
// synchronous to it.
module audio_ser_tx #(
    parameter int SAMPLE_W = 32,
    parameter int PCM_W    = 8,
    localparam int WID_W   = $clog2(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_ratio,
    input  logic                cfg_pcm,
    input  logic [WID_W-1:0]    cfg_wid_m1,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                bclk,
    output logic                fclk,
    output logic                sdata,
    output logic                underrun
);

    logic                slot_end;
    logic                frame_end;
    logic                nxt_left;
    logic                nxt_half_start;
    logic [SAMPLE_W-1:0] load_left;
    logic [SAMPLE_W-1:0] act_right;

    aso_timebase u_tb (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_ratio      (cfg_ratio),
        .bclk           (bclk),
        .slot_end       (slot_end),
        .frame_end      (frame_end),
        .nxt_left       (nxt_left),
        .nxt_half_start (nxt_half_start)
    );

    aso_hold #(.W(SAMPLE_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .in_ready  (in_ready),
        .frame_end (frame_end),
        .load_left (load_left),
        .act_right (act_right),
        .underrun  (underrun)
    );

    aso_shift #(.W(SAMPLE_W), .PCM_W(PCM_W)) u_sh (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_pcm        (cfg_pcm),
        .cfg_wid_m1     (cfg_wid_m1),
        .slot_end       (slot_end),
        .frame_end      (frame_end),
        .nxt_left       (nxt_left),
        .nxt_half_start (nxt_half_start),
        .smp_left       (load_left),
        .smp_right      (act_right),
        .sdata          (sdata),
        .fclk           (fclk)
    );

endmodule

// File: rtl/audio_ser_tx_chk.sv
`timescale 1ns/1ps
// Checker for the audio serial transmitter, attached by bind.
// It watches pin timing, the handshake and the underrun flag.
module audio_ser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bclk,
    input logic fclk,
    input logic sdata,
    input logic in_valid,
    input logic in_ready,
    input logic underrun
);

    logic [3:0] hi_cnt;

    // Counts consecutive master cycles with bclk high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (bclk) begin
            hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    p_bclk_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= 4'd6);

    p_sdata_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> $fell(bclk));

    p_fclk_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fclk) |-> $fell(bclk));

    p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(in_valid));

    p_accept_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

endmodule

bind audio_ser_tx audio_ser_tx_chk u_chk (.*);

// File: tb/audio_ser_tx_test.sv
`timescale 1ns/1ps
module audio_ser_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_ratio = 2'd0;
    logic        cfg_pcm = 1'b0;
    logic [4:0]  cfg_wid_m1 = 5'd15;
    logic [31:0] in_left = '0;
    logic [31:0] in_right = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        bclk;
    logic        fclk;
    logic        sdata;
    logic        underrun;

    int nchk = 0;
    int nfail = 0;
    bit cap_sd [0:63];
    bit cap_fc [0:63];

    audio_ser_tx uut (
        .clk(clk), .rst_n(rst_n), .cfg_ratio(cfg_ratio), .cfg_pcm(cfg_pcm),
        .cfg_wid_m1(cfg_wid_m1), .in_left(in_left), .in_right(in_right),
        .in_valid(in_valid), .in_ready(in_ready), .bclk(bclk), .fclk(fclk),
        .sdata(sdata), .underrun(underrun)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] ratio, input logic pcm, input logic [4:0] wm1);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        cfg_ratio = ratio; cfg_pcm = pcm; cfg_wid_m1 = wm1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [31:0] l, input logic [31:0] r);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Records data and frame clock at the next n bit-clock rises
    task automatic grab(input int n, input int off);
        for (int i = 0; i < n; i++) begin
            @(posedge bclk);
            #1;
            cap_sd[off+i] = sdata;
            cap_fc[off+i] = fclk;
        end
    endtask

    // Compares a captured left-justified frame against the expected pattern
    task automatic check_lj(input string tag, input int n, input int w,
                            input logic [31:0] l, input logic [31:0] r);
        int errs = 0;
        int first = -1;
        for (int i = 0; i < n; i++) begin
            int half = n / 2;
            int idx = (i < half) ? i : i - half;
            logic [31:0] wd = (i < half) ? l : r;
            bit efc = (i < half);
            bit esd = (idx < w) ? wd[w-1-idx] : 1'b0;
            if (cap_sd[i] !== esd || cap_fc[i] !== efc) begin
                errs++;
                if (first < 0) first = i;
            end
        end
        chk(errs == 0, tag, $sformatf("left-justified frame mismatches (first slot %0d)", first), errs, 0);
    endtask

    task automatic t_reset;
        do_reset(2'd0, 1'b0, 5'd15);
        #1;
        chk(bclk == 1'b0 && fclk == 1'b1 && sdata == 1'b0, "R11", "pins after reset",
            {bclk, fclk, sdata}, 3'b010);
        chk(in_ready == 1'b1 && underrun == 1'b0, "R11", "ready/underrun after reset",
            {in_ready, underrun}, 2'b10);
        grab(32, 0);
        check_lj("R11", 32, 16, 32'h0, 32'h0);
    endtask

    task automatic t_rate(input logic [1:0] code);
        time t0, t1;
        int  div   = code[0] ? 12 : 8;
        int  ratio = code == 2'd0 ? 256 : code == 2'd1 ? 384 : code == 2'd2 ? 512 : 768;
        do_reset(code, 1'b0, 5'd15);
        @(posedge bclk); t0 = $time;
        @(posedge bclk); t1 = $time;
        chk((t1 - t0) == time'(div * 10), "R1", "bit clock period (ns)", t1 - t0, div * 10);
        @(posedge fclk); t0 = $time;
        @(posedge fclk); t1 = $time;
        chk((t1 - t0) == time'(ratio * 10), "R2", "frame period (ns)", t1 - t0, ratio * 10);
    endtask

    task automatic t_lj(input string tag, input logic [1:0] code, input int w,
                        input logic [31:0] l, input logic [31:0] r);
        int n = code[1] ? 64 : 32;
        do_reset(code, 1'b0, 5'(w - 1));
        fork
            push(l, r);
            grab(n, 0);
        join
        grab(n, 0);
        check_lj(tag, n, w, l, r);
        chk(underrun == 1'b0, "R9", "no underrun when sample supplied", underrun, 0);
    endtask

    task automatic t_pcm(input logic [1:0] code, input logic [7:0] b);
        int n = code[1] ? 64 : 32;
        int errs = 0;
        do_reset(code, 1'b1, 5'd31);
        fork
            push({24'hABCDEF, b}, 32'hFFFF_FFFF);
            grab(n, 0);
        join
        grab(n, 0);
        for (int i = 0; i < n; i++) begin
            bit efc = (i == 0);
            bit esd = (i >= 1 && i <= 8) ? b[8-i] : 1'b0;
            if (cap_sd[i] !== esd || cap_fc[i] !== efc) errs++;
        end
        chk(errs == 0, "R6", $sformatf("PCM frame mismatches, %0d slots", n), errs, 0);
    endtask

    task automatic t_handshake;
        do_reset(2'd0, 1'b0, 5'd15);
        fork
            push(32'h1111, 32'h2222);
            grab(32, 0);
        join
        chk(in_ready == 1'b0, "R8", "ready low while sample pending", in_ready, 0);
        grab(1, 0);
        chk(in_ready == 1'b1, "R8", "ready back after frame start", in_ready, 1);
        push(32'h3333, 32'h4444);
        #1;
        chk(in_ready == 1'b0, "R8", "ready low after second accept", in_ready, 0);
    endtask

    task automatic t_underrun;
        do_reset(2'd0, 1'b0, 5'd15);
        fork
            push(32'h0000_A5C3, 32'h0000_0F0F);
            grab(32, 0);
        join
        grab(32, 0);
        check_lj("R9", 32, 16, 32'hA5C3, 32'h0F0F);
        chk(underrun == 1'b0, "R9", "flag clear while samples arrive", underrun, 0);
        grab(32, 0);
        check_lj("R9", 32, 16, 32'hA5C3, 32'h0F0F);
        chk(underrun == 1'b1, "R9", "flag set on starved frame", underrun, 1);
        fork
            push(32'h0000_1234, 32'h0000_8001);
            grab(32, 0);
        join
        check_lj("R9", 32, 16, 32'h1234, 32'h8001);
        chk(underrun == 1'b1, "R9", "flag stays set", underrun, 1);
    endtask

    task automatic t_cfg_change;
        do_reset(2'd0, 1'b0, 5'd15);
        fork
            push(32'h0000_C0DE, 32'h0000_7E57);
            grab(32, 0);
        join
        fork
            push(32'h0000_00B6, 32'h0000_0049);
            begin
                grab(8, 0);
                cfg_wid_m1 = 5'd7;
                cfg_ratio  = 2'd2;
                grab(24, 8);
            end
        join
        check_lj("R10", 32, 16, 32'hC0DE, 32'h7E57);
        grab(64, 0);
        check_lj("R10", 64, 8, 32'hB6, 32'h49);
    endtask

    initial begin
        t_reset();
        t_rate(2'd0);
        t_rate(2'd1);
        t_rate(2'd2);
        t_rate(2'd3);
        t_lj("R3", 2'd2, 24, 32'hFFA5_C3E1, 32'h5512_3456);
        t_lj("R5", 2'd0, 16, 32'h1234_BEEF, 32'hFFFF_8001);
        t_lj("R4", 2'd0, 32, 32'hDEAD_BEEF, 32'h0123_4567);
        t_lj("R3", 2'd3, 20, 32'h000F_0A5C, 32'h0008_1234);
        t_pcm(2'd0, 8'h5A);
        t_pcm(2'd3, 8'h81);
        t_handshake();
        t_underrun();
        t_cfg_change();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule